// File: doc/BRIEF.md
# Page-Wrapping Write Buffer with Deferred Commit

This block gathers the data bytes of one write command into a small staging store and copies them into an on-chip byte array only when a commit strobe arrives. A start address is loaded first. Each data byte then lands in the staging slot chosen by the low bits of a running address pointer, and that pointer steps forward. The pointer's upper bits, which select the page, never change on a step, so both the pointer and the staging store wrap inside one page. If more bytes arrive than a page holds, later bytes replace the earliest ones.

On commit the filled slots are copied, one slot per cycle, into the array at the page the pointer names. A busy flag is raised for a parameterised number of cycles, and every strobe is ignored while it is high. With write protect high at commit, the array is left alone and busy stays low, but the pointer keeps the steps taken by the received bytes. An abort strobe drops the staged bytes and keeps the pointer. A registered debug read port exposes the array contents. Serial protocol handling belongs to a surrounding block.

With `ADDR_W` = 13 the array holds 8192 bytes. The default of 11 keeps elaboration small, and the page logic is identical.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy_o` is 0 and `ptr_o` is 0.
- R2: An accepted load sets `ptr_o` to `load_addr_i` from the next cycle and discards any staged bytes.
- R3: Each accepted byte adds one to the low `PAGE_W` bits of `ptr_o` (modulo 2^`PAGE_W`) and leaves the upper bits unchanged. With `PAGE_W` = 5, 0x01F steps to 0x000 and 0x7FF steps to 0x7E0.
- R4: A commit with `wp_i` low writes each staged byte to address {`ptr_o` page bits, slot index}. The slot index is the low `PAGE_W` bits the pointer held when the byte arrived. Array locations with no staged byte keep their contents.
- R5: When more than 2^`PAGE_W` bytes arrive before a commit, a later byte replaces the earlier byte that used the same slot.
- R6: A commit with `wp_i` low raises `busy_o` in the next cycle. `busy_o` then stays high for exactly HOLD = max(`BUSY_CYCLES`, 2^`PAGE_W`) cycles.
- R7: A commit with `wp_i` high leaves `busy_o` low and the array unchanged. `ptr_o` keeps the steps from the received bytes, and the staged bytes are dropped.
- R8: An abort drops the staged bytes without writing them, so a following commit leaves the array unchanged. `ptr_o` keeps its value.
- R9: While `busy_o` is high, load, byte, commit and abort strobes are ignored.
- R10: `dbg_data_o` shows the array byte at `dbg_addr_i` one clock after the address is presented.
- R11: When several strobes arrive in the same idle cycle, only one is taken, in the priority order commit, abort, load, byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load start address strobe |
| load_addr_i | input | ADDR_W | Start address |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Commit staged bytes |
| abort_i | input | 1 | Drop staged bytes |
| wp_i | input | 1 | Write protect, sampled with commit |
| busy_o | output | 1 | Commit in progress |
| ptr_o | output | ADDR_W | Current address pointer |
| dbg_addr_i | input | ADDR_W | Debug read address |
| dbg_data_o | output | DATA_W | Debug read data (one cycle latency) |

## Verification
The bench builds the block with `ADDR_W` = 11, `PAGE_W` = 5 and `BUSY_CYCLES` = 36. These values make the wraps from 0x01F to 0x000 and from 0x7FF to 0x7E0 reachable, along with a 35-byte overflow of a 32-slot page. With `BUSY_CYCLES` above the page size, the busy window outlasts the copy walk, so a strobe issued late in that window is seen to be ignored. A known page pattern is written first, so that partial, protected and aborted commits can each be shown to leave the untouched locations intact.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_COMMIT,
    OP_SEAL,
    OP_ABORT,
    OP_LOAD,
    OP_BYTE
  } op_e;

  function automatic int hold_len(input int busy_cycles, input int page_bytes);
    return (busy_cycles < page_bytes) ? page_bytes : busy_cycles;
  endfunction

endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_addr;
    end else if (step) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
    end
  end

endmodule

// File: rtl/pgbuf_slots.sv
module pgbuf_slots #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] store [SLOTS];
  logic [SLOTS-1:0]  mask;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask <= '0;
    end else if (wr_en) begin
      mask[wr_slot] <= 1'b1;
    end
  end

  assign rd_data = store[rd_slot];
  assign rd_vld  = mask[rd_slot];

endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq #(
  parameter int HOLD   = 36,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              busy,
  output logic              walk,
  output logic [PAGE_W-1:0] slot,
  output logic              done
);

  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(HOLD - 1);
  localparam logic [CNT_W-1:0] SLOTS = CNT_W'(1 << PAGE_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign walk = busy && (cnt < SLOTS);
  assign slot = cnt[PAGE_W-1:0];
  assign done = busy && (cnt == LAST);

endmodule

// File: rtl/pgbuf_mem.sv
module pgbuf_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [DATA_W-1:0] dbg_data_o
);

  localparam int HOLD = hold_len(BUSY_CYCLES, 1 << PAGE_W);

  op_e               op;
  logic              busy;
  logic              walk;
  logic              seq_done;
  logic [PAGE_W-1:0] walk_slot;
  logic [DATA_W-1:0] slot_data;
  logic              slot_vld;
  logic [ADDR_W-1:0] ptr;
  logic              mask_clr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  // One operation per idle cycle: commit, abort, load, byte (R11).
  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (commit_i)        op = wp_i ? OP_SEAL : OP_COMMIT;
      else if (abort_i)    op = OP_ABORT;
      else if (load_i)     op = OP_LOAD;
      else if (byte_vld_i) op = OP_BYTE;
    end
  end

  assign mask_clr = (op == OP_SEAL) || (op == OP_ABORT) || (op == OP_LOAD) || seq_done;

  pgbuf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (op == OP_LOAD),
    .load_addr (load_addr_i),
    .step      (op == OP_BYTE),
    .ptr       (ptr)
  );

  pgbuf_slots #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (op == OP_BYTE),
    .wr_slot (ptr[PAGE_W-1:0]),
    .wr_data (byte_i),
    .clr     (mask_clr),
    .rd_slot (walk_slot),
    .rd_data (slot_data),
    .rd_vld  (slot_vld)
  );

  pgbuf_seq #(.HOLD(HOLD), .PAGE_W(PAGE_W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .go   (op == OP_COMMIT),
    .busy (busy),
    .walk (walk),
    .slot (walk_slot),
    .done (seq_done)
  );

  // The page bits of the pointer cannot move while busy, so they name the target page.
  assign mem_we    = walk && slot_vld;
  assign mem_waddr = {ptr[ADDR_W-1:PAGE_W], walk_slot};

  pgbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (slot_data),
    .raddr (dbg_addr_i),
    .rdata (dbg_data_o)
  );

  assign busy_o = busy;
  assign ptr_o  = ptr;

endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic              byte_vld_i,
  input logic              commit_i,
  input logic              abort_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o
);

  localparam int HOLD = hold_len(BUSY_CYCLES, 1 << PAGE_W);
  localparam int RUN_W = $clog2(HOLD + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_o) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_q == RUN_W'(HOLD)));

  p_commit_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !wp_i && !busy_o) |=> busy_o);

  p_wp_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_i && wp_i && !busy_o) |=> !busy_o);

  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(ptr_o));

  p_load_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    (load_i && !busy_o && !commit_i && !abort_i) |=> (ptr_o == $past(load_addr_i)));

  p_abort_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_i && !busy_o && !commit_i) |=> $stable(ptr_o));

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !busy_o && !load_i && !commit_i && !abort_i) |=>
      ((ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W])) &&
       (ptr_o[PAGE_W-1:0] == PAGE_W'($past(ptr_o[PAGE_W-1:0]) + PAGE_W'(1)))));

endmodule

bind pgbuf_commit pgbuf_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .load_addr_i (load_addr_i),
  .byte_vld_i  (byte_vld_i),
  .commit_i    (commit_i),
  .abort_i     (abort_i),
  .wp_i        (wp_i),
  .busy_o      (busy_o),
  .ptr_o       (ptr_o)
);

// File: tb/pgbuf_commit_tb.sv
module pgbuf_commit_tb;

  localparam int AW = 11, PW = 5, DW = 8, BC = 36;
  localparam int HOLD = 36, SLOTS = 32, DEPTH = 2048;

  logic          clk = 1'b0, rst = 1'b1;
  logic          load_i = 0, byte_vld_i = 0, commit_i = 0, abort_i = 0, wp_i = 0;
  logic [AW-1:0] load_addr_i = '0, dbg_addr_i = '0;
  logic [DW-1:0] byte_i = '0;
  logic          busy_o;
  logic [AW-1:0] ptr_o;
  logic [DW-1:0] dbg_data_o;

  pgbuf_commit #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .BUSY_CYCLES(BC)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] mmem [DEPTH];
  bit            mknown [DEPTH];
  logic [DW-1:0] mbuf [SLOTS];
  bit            mmask [SLOTS];
  logic [AW-1:0] mptr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_model();
    for (int i = 0; i < SLOTS; i++) mmask[i] = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    load_i = 1; load_addr_i = a; @(negedge clk); load_i = 0;
    mptr = a; clr_model();
  endtask

  task automatic put(input logic [DW-1:0] d);
    byte_vld_i = 1; byte_i = d; @(negedge clk); byte_vld_i = 0;
    mbuf[mptr[PW-1:0]] = d; mmask[mptr[PW-1:0]] = 1;
    mptr[PW-1:0] = mptr[PW-1:0] + 5'd1;
  endtask

  task automatic do_commit(input bit p, output int n);
    commit_i = 1; wp_i = p; @(negedge clk); commit_i = 0; wp_i = 0;
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    if (!p)
      for (int i = 0; i < SLOTS; i++)
        if (mmask[i]) begin
          mmem[{mptr[AW-1:PW], 5'(i)}] = mbuf[i];
          mknown[{mptr[AW-1:PW], 5'(i)}] = 1;
        end
    clr_model();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    dbg_addr_i = a; @(negedge clk); d = dbg_data_o;
  endtask

  task automatic check_page(input logic [AW-1:0] base, input string tag);
    logic [DW-1:0] d;
    for (int i = 0; i < SLOTS; i++) begin
      logic [AW-1:0] a;
      a = {base[AW-1:PW], 5'(i)};
      if (mknown[a]) begin
        rd(a, d);
        chk(d === mmem[a], $sformatf("%s addr %0h", tag, a), int'(d), int'(mmem[a]));
      end
    end
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R1 busy after reset", int'(busy_o), 0);
    chk(ptr_o === '0, "R1 ptr after reset", int'(ptr_o), 0);
  endtask

  task automatic t_full_page();
    int n;
    do_load(11'h040);
    chk(ptr_o === 11'h040, "R2 ptr after load", int'(ptr_o), 'h40);
    for (int i = 0; i < SLOTS; i++) put(8'(8'h30 + i));
    chk(ptr_o === 11'h040, "R3 ptr after full page", int'(ptr_o), 'h40);
    do_commit(0, n);
    chk(n == HOLD, "R6 busy length", n, HOLD);
    check_page(11'h040, "R4 R10 full page");
  endtask

  task automatic t_partial();
    int n;
    do_load(11'h045);
    put(8'hA1); put(8'hA2); put(8'hA3);
    chk(ptr_o === 11'h048, "R3 ptr after three bytes", int'(ptr_o), 'h48);
    do_commit(0, n);
    check_page(11'h040, "R4 partial page");
  endtask

  task automatic t_wrap();
    int n;
    logic [DW-1:0] d;
    do_load(11'h01F); put(8'h5C);
    chk(ptr_o === 11'h000, "R3 wrap 01F", int'(ptr_o), 0);
    do_commit(0, n);
    rd(11'h01F, d);
    chk(d === 8'h5C, "R4 byte at 01F", int'(d), 'h5C);
    do_load(11'h7FF); put(8'h11); put(8'h22);
    chk(ptr_o === 11'h7E1, "R3 wrap 7FF", int'(ptr_o), 'h7E1);
    do_commit(0, n);
    check_page(11'h7E0, "R4 top page");
  endtask

  task automatic t_overflow();
    int n;
    do_load(11'h100);
    for (int i = 0; i < 35; i++) put(8'(8'h80 + i));
    chk(ptr_o === 11'h103, "R5 ptr after 35 bytes", int'(ptr_o), 'h103);
    do_commit(0, n);
    chk(mmem[11'h100] === 8'hA0, "R5 model slot 0", int'(mmem[11'h100]), 'hA0);
    check_page(11'h100, "R5 overflow page");
  endtask

  task automatic t_protect();
    int n;
    do_load(11'h045); put(8'hEE); put(8'hEF);
    do_commit(1, n);
    chk(n == 0, "R7 busy stays low", n, 0);
    chk(ptr_o === 11'h047, "R7 ptr keeps steps", int'(ptr_o), 'h47);
    check_page(11'h040, "R7 page unchanged");
    do_commit(0, n);
    check_page(11'h040, "R7 staged bytes dropped");
  endtask

  task automatic t_abort();
    int n;
    do_load(11'h048); put(8'hD1); put(8'hD2);
    abort_i = 1; @(negedge clk); abort_i = 0; clr_model();
    chk(ptr_o === 11'h04A, "R8 ptr kept", int'(ptr_o), 'h4A);
    do_commit(0, n);
    check_page(11'h040, "R8 page unchanged");
  endtask

  task automatic t_busy_ignore();
    int n;
    do_load(11'h050); put(8'hA5);
    commit_i = 1; @(negedge clk); commit_i = 0;
    n = 1;
    load_i = 1; load_addr_i = 11'h300; byte_vld_i = 1; byte_i = 8'h77; abort_i = 1; commit_i = 1;
    repeat (3) begin @(negedge clk); n++; end
    load_i = 0; byte_vld_i = 0; abort_i = 0; commit_i = 0;
    while (busy_o && n < 1000) begin @(negedge clk); n++; end
    // n counts busy samples plus the final low one
    chk(n - 1 == HOLD, "R9 busy not extended", n - 1, HOLD);
    chk(ptr_o === 11'h051, "R9 ptr ignored strobes", int'(ptr_o), 'h51);
    mmem[11'h050] = 8'hA5; mknown[11'h050] = 1; clr_model();
    do_commit(0, n);
    check_page(11'h040, "R9 no ignored byte written");
  endtask

  task automatic t_priority();
    int n;
    load_i = 1; load_addr_i = 11'h0A3; byte_vld_i = 1; byte_i = 8'h99;
    @(negedge clk); load_i = 0; byte_vld_i = 0;
    mptr = 11'h0A3; clr_model();
    chk(ptr_o === 11'h0A3, "R11 load wins over byte", int'(ptr_o), 'hA3);
    do_load(11'h044); put(8'h66);
    abort_i = 1; load_i = 1; load_addr_i = 11'h222;
    @(negedge clk); abort_i = 0; load_i = 0; clr_model();
    chk(ptr_o === 11'h045, "R11 abort wins over load", int'(ptr_o), 'h45);
    do_commit(0, n);
    check_page(11'h040, "R11 aborted byte absent");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mknown[i] = 0;
    clr_model();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_partial();
    t_wrap();
    t_overflow();
    t_protect();
    t_abort();
    t_busy_ignore();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule